// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Line Break

This block sends bytes as asynchronous serial frames on a single output line. Software pushes bytes into a 16-entry queue through a small register bus; a shift engine pops them one at a time and sends each as a frame of one low start bit, eight data bits (least significant first) and one high stop bit. The bit rate is set by an 8-bit divider: a tick fires every (divider + 1) clocks and one bit lasts 16 ticks.

Software tracks progress through three status flags: one saying the queue has dropped to a selectable watermark, one saying everything has gone out, and one that records a write lost to a full queue. It can also read the queue fill level directly. The first two flags follow a handshake: they clear only when software writes 0 after it has seen them read as 1. To send a break, software sets a line-override enable with a low override level, then turns the transmitter off. The override then owns the line.

Register select codes on `reg_sel`: 0 = push data byte, 1 = control (bit 0 transmitter on, bits 2:1 watermark code), 2 = bit-rate divider, 3 = status clear, 4 = line override (bit 0 enable, bit 1 level). The status output `stat_o` is {overflow, done, room} in bits 2:0.

Top module: `serial_tx_unit`

## Requirements
- R1: Each frame is a low start bit, the 8 data bits least significant first, then a high stop bit. The line is high whenever no frame is being sent.
- R2: Every bit lasts exactly 16 x (divider + 1) clock cycles, where the divider comes from register select 2.
- R3: The queue holds 16 bytes. A push to a full queue is dropped and sets `stat_o[2]`. That bit stays set until a status-clear write (select 3) has bit 2 = 0.
- R4: `fill_o` always equals the number of bytes waiting in the queue (0 to 16). The byte being sent is no longer counted.
- R5: `stat_o[0]` (room) is set in the cycle after any cycle in which `fill_o` is at or below the watermark. The watermark is 0, 2, 4 or 8 for control bits 2:1 = 0, 1, 2, 3.
- R6: A status-clear write with bit 0 (room) or bit 1 (done) equal to 0 clears that flag only if a `stat_rd` strobe since the previous status-clear write saw the flag at 1. Writing 1 to a bit leaves that flag unchanged.
- R7: `stat_o[1]` (done) is set when a stop bit finishes with the queue empty. Any data push clears it.
- R8: Clearing the transmitter-on bit returns the line high at once, unless the override is enabled. A frame in progress is abandoned and its byte is not sent again.
- R9: While the transmitter is off and override enable is 1, the line equals the override level (level 0 sends a break). While the transmitter is on, the override has no effect.
- R10: After reset the line is high, `fill_o` is 0, `stat_o` is 3'b011 (room and done set, no overflow), the transmitter is off and the divider and watermark code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe (arms the clear handshake) |
| stat_o | output | 3 | {overflow, done, room} |
| fill_o | output | 5 | Bytes waiting in the queue |
| txd_o | output | 1 | Serial output line |

## Verification
A wrong queue pointer or count shows up on `fill_o` in the cycle after the push or pop that caused it. Within a frame it also shows as a wrong or repeated byte on the line. A wrong shift or bit counter shows up as a misplaced data bit or a wrong bit length, seen within one bit period of the fault. Flag handshake errors show on `stat_o` one cycle after the status write, `stat_rd` strobe or frame end that should have moved them. An override or abort fault shows on `txd_o` in the cycle right after the control write.

// File: rtl/serial_tx_pkg.sv
// Shared definitions for the buffered serial transmitter.
// Assumes: register select codes are fixed by software convention.
package serial_tx_pkg;

    typedef enum logic [2:0] {
        SEL_DATA = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_DIV  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_PIN  = 3'd4
    } reg_sel_e;

    // Watermark for a 2-bit code: 0 -> 0, otherwise 2^code.
    function automatic logic [7:0] trig_level(input logic [1:0] code);
        return (code == 2'd0) ? 8'd0 : (8'd1 << code);
    endfunction

endpackage

// File: rtl/tx_queue.sv
// Byte queue feeding the shift engine.
// The head byte can be read directly (no read latency).
// A push while full is dropped and reported on push_drop.
// Assumes: pop is only raised when not empty.
module tx_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              empty,
    output logic              push_drop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, push_ok;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign push_ok   = push && !full;
    assign push_drop = push && full;
    assign head      = mem[rd_ptr];

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tx_baud.sv
// Bit-rate tick generator: one tick every (div + 1) clocks.
// Assumes: restart lines up the tick phase with the start of a frame.
module tx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count clocks between ticks, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (cnt == div)           cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tx_shifter.sv
// Frame engine: loads the head byte, shifts start, data and stop bits.
// Each bit lasts OS ticks. Dropping tx_en abandons the frame.
// Assumes: head is valid whenever empty is low.
module tx_shifter #(
    parameter int DATA_W = 8,
    parameter int OS     = 16,
    localparam int FW    = DATA_W + 2,
    localparam int BW    = $clog2(FW),
    localparam int SW    = $clog2(OS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              empty,
    input  logic [DATA_W-1:0] head,
    input  logic              tick,
    output logic              pop,
    output logic              busy,
    output logic              line,
    output logic              frame_done
);
    logic [FW-1:0] frame;
    logic [BW-1:0] bit_idx;
    logic [SW-1:0] sub;
    logic          bit_end;

    assign pop        = !busy && tx_en && !empty;
    assign line       = busy ? frame[0] : 1'b1;
    assign bit_end    = busy && tick && (sub == SW'(OS - 1));
    assign frame_done = bit_end && (bit_idx == BW'(FW - 1));

    // Load a frame, step through its bits, or abandon it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            frame   <= '1;
            bit_idx <= '0;
            sub     <= '0;
        end else if (!tx_en) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            sub     <= '0;
        end else if (pop) begin
            busy    <= 1'b1;
            frame   <= {1'b1, head, 1'b0};
            bit_idx <= '0;
            sub     <= '0;
        end else if (busy && tick) begin
            sub <= bit_end ? '0 : sub + 1'b1;
            if (frame_done) begin
                busy <= 1'b0;
            end else if (bit_end) begin
                frame   <= {1'b1, frame[FW-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_flags.sv
// Status flags: room (watermark), done (all sent), overflow (sticky).
// Room and done clear only by a 0-write after being read as 1.
// Assumes: stat_rd marks the cycle in which software samples stat_o.
module tx_flags #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    input  logic [1:0]    trig,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic [2:0]    stat_wdata,
    input  logic          data_push,
    input  logic          push_drop,
    input  logic          frame_done,
    output logic          room,
    output logic          done,
    output logic          ovf,
    output logic          room_clr
);
    logic          seen_room, seen_done, done_clr;
    logic [CW-1:0] lvl;

    assign lvl      = CW'(serial_tx_pkg::trig_level(trig));
    assign room_clr = stat_wr && !stat_wdata[0] && seen_room;
    assign done_clr = (stat_wr && !stat_wdata[1] && seen_done) || data_push;

    // Remember which flags software last saw at 1.
    always_ff @(posedge clk) begin
        if (!rst_n || stat_wr) begin
            seen_room <= 1'b0;
            seen_done <= 1'b0;
        end else if (stat_rd) begin
            seen_room <= room;
            seen_done <= done;
        end
    end

    // Update the three flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            room <= 1'b1;
            done <= 1'b1;
            ovf  <= 1'b0;
        end else begin
            if (room_clr)           room <= 1'b0;
            else if (fill <= lvl)   room <= 1'b1;
            if (done_clr)                         done <= 1'b0;
            else if (frame_done && fill == '0)    done <= 1'b1;
            if (push_drop)                        ovf <= 1'b1;
            else if (stat_wr && !stat_wdata[2])   ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_tx_unit.sv
// Top of the buffered serial transmitter: register decode, queue,
// tick generator, frame engine, flags and line override.
// Assumes: one register access per cycle; reset is synchronous.
module serial_tx_unit #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int OS     = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              stat_rd,
    output logic [2:0]        stat_o,
    output logic [CW-1:0]     fill_o,
    output logic              txd_o
);
    import serial_tx_pkg::*;

    logic             tx_en, ovr_en, ovr_lvl;
    logic [1:0]       trig;
    logic [DIV_W-1:0] div;
    logic             data_push, stat_wr, push_drop, pop, empty, busy;
    logic             tick, line, frame_done, room, done, ovf, room_clr;
    logic [DATA_W-1:0] head;

    assign data_push = reg_we && (reg_sel_e'(reg_sel) == SEL_DATA);
    assign stat_wr   = reg_we && (reg_sel_e'(reg_sel) == SEL_STAT);

    // Control, divider and override registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            trig    <= '0;
            div     <= '0;
            ovr_en  <= 1'b0;
            ovr_lvl <= 1'b1;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    tx_en <= reg_wdata[0];
                    trig  <= reg_wdata[2:1];
                end
                SEL_DIV:  div <= DIV_W'(reg_wdata);
                SEL_PIN: begin
                    ovr_en  <= reg_wdata[0];
                    ovr_lvl <= reg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    tx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(data_push), .push_data(reg_wdata),
        .pop(pop), .head(head), .count(fill_o), .empty(empty),
        .push_drop(push_drop)
    );

    tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(pop), .div(div),
        .tick(tick)
    );

    tx_shifter #(.DATA_W(DATA_W), .OS(OS)) u_shift (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .empty(empty), .head(head),
        .tick(tick), .pop(pop), .busy(busy), .line(line),
        .frame_done(frame_done)
    );

    tx_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n), .fill(fill_o), .trig(trig),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(reg_wdata[2:0]),
        .data_push(data_push), .push_drop(push_drop),
        .frame_done(frame_done), .room(room), .done(done), .ovf(ovf),
        .room_clr(room_clr)
    );

    assign stat_o = {ovf, done, room};
    assign txd_o  = tx_en ? line : (ovr_en ? ovr_lvl : 1'b1);
endmodule

// File: rtl/serial_tx_chk.sv
// Property checker for serial_tx_unit, attached by bind.
// Assumes: internal control state is visible through the bind ports.
module serial_tx_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd_o,
    input logic [CW-1:0] fill_o,
    input logic [2:0]    stat_o,
    input logic          tx_en,
    input logic          ovr_en,
    input logic          ovr_lvl,
    input logic          data_push,
    input logic          room_clr,
    input logic [1:0]    trig
);
    logic [CW-1:0] lvl;
    assign lvl = CW'(serial_tx_pkg::trig_level(trig));

    p_fill_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CW'(DEPTH));

    p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + 1'b1) ||
        (fill_o == $past(fill_o) - 1'b1));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_push && fill_o == CW'(DEPTH)) |=> stat_o[2]);

    p_room_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o <= lvl && !room_clr) |=> stat_o[0]);

    p_done_push_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_push |=> !stat_o[1]);

    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !ovr_en) |-> txd_o);

    p_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && ovr_en) |-> (txd_o == ovr_lvl));
endmodule

bind serial_tx_unit serial_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd_o(txd_o), .fill_o(fill_o),
    .stat_o(stat_o), .tx_en(tx_en), .ovr_en(ovr_en), .ovr_lvl(ovr_lvl),
    .data_push(data_push), .room_clr(room_clr), .trig(trig)
);

// File: tb/serial_tx_unit_test.sv
// Self-checking bench: a vector table of (divider, byte) frames,
// then directed tests for flags, overflow, abort and break.
module serial_tx_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [2:0] stat_o;
    logic [4:0] fill_o;
    logic       txd_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    serial_tx_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .stat_o(stat_o),
        .fill_o(fill_o), .txd_o(txd_o)
    );

    // {divider, data}; every data byte has bit 0 = 1 so the start bit
    // length can be measured.
    localparam logic [15:0] VEC [6] = '{
        16'h00_A5, 16'h01_3B, 16'h02_81, 16'h03_55, 16'h00_FF, 16'h01_01
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lowlen, per, bad;
        logic [7:0] got;
        logic stopb;

        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 txd", txd_o, 1);
        chk("R10 fill", fill_o, 0);
        chk("R10 stat", stat_o, 3'b011);

        // R1/R2/R7: table of frames
        for (int v = 0; v < 6; v++) begin
            per = 16 * (VEC[v][15:8] + 1);
            wr(3'd2, VEC[v][15:8]);
            wr(3'd0, VEC[v][7:0]);
            wr(3'd1, 8'h01);
            while (txd_o !== 1'b0) @(negedge clk);
            lowlen = 0;
            while (txd_o === 1'b0) begin
                lowlen++;
                @(negedge clk);
            end
            chk("R2 bit period", lowlen, per);
            wait_cyc(per / 2);
            got[0] = txd_o;
            for (int b = 1; b < 8; b++) begin
                wait_cyc(per);
                got[b] = txd_o;
            end
            wait_cyc(per);
            stopb = txd_o;
            chk("R1 data", got, VEC[v][7:0]);
            chk("R1 stop", stopb, 1);
            wait_cyc(per / 2 + 3);
            chk("R7 done after frame", stat_o[1], 1);
            wr(3'd1, 8'h00);
        end

        // R7: push clears done (transmitter off, byte stays queued)
        wr(3'd0, 8'h5B);
        chk("R7 done cleared by push", stat_o[1], 0);
        chk("R4 fill one", fill_o, 1);

        // R8: abort mid-frame
        wr(3'd2, 8'd3);
        wr(3'd1, 8'h01);
        while (txd_o !== 1'b0) @(negedge clk);
        wait_cyc(100);
        wr(3'd1, 8'h00);
        chk("R8 line high after disable", txd_o, 1);
        bad = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (txd_o !== 1'b1) bad++;
        end
        chk("R8 no line activity", bad, 0);
        chk("R8 byte not requeued", fill_o, 0);

        // R3/R4: fill with 17 pushes while off
        for (int i = 0; i < 17; i++) wr(3'd0, 8'(i * 3 + 1));
        chk("R4 fill full", fill_o, 16);
        chk("R3 overflow set", stat_o[2], 1);
        wr(3'd3, 8'b011);
        chk("R3 overflow cleared", stat_o[2], 0);

        // R6/R5: room clear handshake and watermark 8
        wr(3'd3, 8'b110);
        chk("R6 room kept without read", stat_o[0], 1);
        rd_pulse();
        wr(3'd3, 8'b110);
        chk("R6 room cleared after read", stat_o[0], 0);
        wr(3'd2, 8'd0);
        wr(3'd1, 8'h07);
        bad = 0;
        while (fill_o > 5'd8) begin
            if (stat_o[0] !== 1'b0) bad++;
            @(negedge clk);
        end
        chk("R5 room low above watermark", bad, 0);
        @(negedge clk);
        chk("R5 room set at watermark", stat_o[0], 1);
        bad = 0;
        while (stat_o[1] !== 1'b1 && bad < 5000) begin
            bad++;
            @(negedge clk);
        end
        chk("R7 done after drain", stat_o[1], 1);
        chk("R4 fill drained", fill_o, 0);

        // R6: done clear handshake
        wr(3'd3, 8'b101);
        chk("R6 done kept without read", stat_o[1], 1);
        rd_pulse();
        wr(3'd3, 8'b101);
        chk("R6 done cleared after read", stat_o[1], 0);

        // R9: break through the line override
        wr(3'd4, 8'b01);
        chk("R9 override ignored while on", txd_o, 1);
        wr(3'd1, 8'h00);
        chk("R9 break low", txd_o, 0);
        wr(3'd4, 8'b11);
        chk("R9 override high", txd_o, 1);
        wr(3'd4, 8'b01);
        chk("R9 break again", txd_o, 0);
        wr(3'd4, 8'b00);
        chk("R8 idle high override off", txd_o, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule